// File: doc/BRIEF.md
# Triggered Capture Write Controller

This block records a bundle of probed signals, one sample per clock, into a circular capture memory. Software arms it through a small bank of 7-bit registers, written over a simple bus write port. Before the trigger, samples keep overwriting the ring. When the trigger condition is met, exactly the post-trigger number of further samples is stored, and the capture then stops. The stored window is therefore split around the trigger sample in a chosen ratio.

When the last write has landed in the memory, the block latches the address of the oldest sample in the window and raises a done flag. It also drops the arm bit, so one arming yields one capture. A readout path outside this block then walks the memory from that start address, through a plain read port on the array.

Top module: `trig_capture_top`

## Requirements
- R1: Each register holds 7 bits. A bus write stores only busWdata[6:0], and busRdata bits above 6 always read 0. The register at address 2 (status) and the register at address 3 (start address) are read-only: a write to them changes nothing.
- R2: After reset, the registers read back their defaults: address 0 (control) = 0x08, address 1 (depth) = 0x20, status = 0, start address = 0. captureDone is 0.
- R3: Parameter RST_ACTIVE_HIGH selects the reset level: 0 means rstIn low resets, 1 means rstIn high resets. Reset is applied at the clock edge and returns every register to its default, even during a capture.
- R4: While armed, one probe sample is written every clock cycle. Writes go into a ring whose length recLen is the depth register value. A depth of 0, or a depth above MEM_DEPTH, gives recLen = MEM_DEPTH.
- R5: Control bits [4:3] pick the split. Code 0 means 30/70, code 1 and code 3 mean 50/50, code 2 means 70/30. The number of samples before the trigger is pre = floor(recLen*p/10), with p = 3, 5 or 7. The remaining recLen-pre samples start with the trigger sample itself.
- R6: Control bits [2:1] pick the trigger type: 0 rising edge, 1 falling edge, 2 high level, 3 low level. Edges are judged against the previous clock's trigger sample.
- R7: A trigger condition is ignored until at least pre samples have been written since arming.
- R8: After the last post-trigger write has reached memory, several things happen together. captureDone and status bit 0 become 1. The start-address register holds the oldest sample's address. Reading the ring from that address, modulo recLen, returns the window in time order.
- R9: Writing control bit 0 = 1 arms the block. Completion clears that bit, and later trigger activity causes no further capture or memory write until the block is armed again.
- R10: Re-arming clears captureDone and the status bit within one cycle of the arm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstIn | input | 1 | Reset, level set by RST_ACTIVE_HIGH |
| probeIn | input | PROBE_W | Probed signal bundle |
| trigIn | input | 1 | Trigger source |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | BUS_W | Register write data |
| busRdata | output | BUS_W | Register read data for busAddr |
| memRdAddr | input | AW | Capture memory read address |
| memRdData | output | PROBE_W | Capture memory read data |
| captureDone | output | 1 | Capture finished |

## Verification
A wrong write pointer or sample count shows up at the memory read port as a window that is shifted or broken. It becomes visible on the first readout after done, as soon as the bench walks the ring from the start address. A trigger qualifier that fires too early, or a split that is decoded wrongly, moves the trigger sample away from offset pre in that readout. An arm bit that fails to clear shows up within a few dozen cycles: a later trigger edge then rewrites memory, or changes the start address.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
  localparam int REG_W = 7;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DEPTH  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_START  = 2'd3;

  localparam logic [REG_W-1:0] CTRL_DEFAULT  = 7'h08;
  localparam logic [REG_W-1:0] DEPTH_DEFAULT = 7'h20;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_POST,
    ST_FLUSH
  } cap_state_e;

  typedef struct packed {
    logic wrEn;
    logic wrLast;
  } wr_strobe_t;

  function automatic logic [3:0] splitTenths(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd3;
      2'd2:    return 4'd7;
      default: return 4'd5;
    endcase
  endfunction
endpackage

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import trig_capture_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int AW        = 6,
  parameter int LW        = 7,
  parameter int BUS_W     = 16
) (
  input  logic             clk,
  input  logic             rstAct,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic             trigHit,
  input  logic             commitLast,
  output trig_mode_e       trigMode,
  output wr_strobe_t       strb,
  output logic [AW-1:0]    wrAddr,
  output logic             captureDone,
  output logic             armBit,
  output logic [LW-1:0]    recLen
);
  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] depthReg;
  logic             doneBit;
  logic [AW-1:0]    startReg;

  cap_state_e    state;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] nextPtr;
  logic [LW-1:0] fillCnt;
  logic [LW-1:0] postCnt;
  logic [LW-1:0] preLen;
  logic [LW-1:0] postLen;
  logic [LW+3:0] preProd;
  logic          accept;
  logic          finishPulse;

  assign armBit      = ctrlReg[0];
  assign trigMode    = trig_mode_e'(ctrlReg[2:1]);
  assign captureDone = doneBit;
  assign wrAddr      = wrPtr;

  // Ring length and the pre/post split of the window
  always_comb begin
    if (int'(depthReg) == 0 || int'(depthReg) > MEM_DEPTH) recLen = LW'(MEM_DEPTH);
    else                                                   recLen = LW'(depthReg);
    preProd = {4'b0, recLen} * {{LW{1'b0}}, splitTenths(ctrlReg[4:3])};
    preLen  = LW'(preProd / (LW+4)'(10));
    postLen = recLen - preLen;
  end

  assign nextPtr     = (LW'(wrPtr) == recLen - LW'(1)) ? '0 : wrPtr + AW'(1);
  assign accept      = trigHit && (fillCnt >= preLen);
  assign finishPulse = (state == ST_FLUSH) && commitLast;

  always_comb begin
    strb.wrEn   = (state == ST_FILL) || (state == ST_POST);
    strb.wrLast = ((state == ST_FILL) && accept && (postLen == LW'(1))) ||
                  ((state == ST_POST) && ((postCnt + LW'(1)) == postLen));
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rstAct) begin
      ctrlReg  <= CTRL_DEFAULT;
      depthReg <= DEPTH_DEFAULT;
    end else begin
      if (finishPulse) ctrlReg[0] <= 1'b0;
      if (busWe && busAddr == ADDR_CTRL)  ctrlReg  <= busWdata[REG_W-1:0];
      if (busWe && busAddr == ADDR_DEPTH) depthReg <= busWdata[REG_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:   busRdata[REG_W-1:0] = ctrlReg;
      ADDR_DEPTH:  busRdata[REG_W-1:0] = depthReg;
      ADDR_STATUS: busRdata[0]         = doneBit;
      default:     busRdata[AW-1:0]    = startReg;
    endcase
  end

  // Capture sequencer
  always_ff @(posedge clk) begin
    if (rstAct) begin
      state    <= ST_IDLE;
      wrPtr    <= '0;
      fillCnt  <= '0;
      postCnt  <= '0;
      doneBit  <= 1'b0;
      startReg <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (armBit) begin
            state   <= ST_FILL;
            wrPtr   <= '0;
            fillCnt <= '0;
            postCnt <= '0;
            doneBit <= 1'b0;
          end
        end
        ST_FILL: begin
          wrPtr <= nextPtr;
          if (fillCnt < recLen) fillCnt <= fillCnt + LW'(1);
          if (accept) begin
            postCnt <= LW'(1);
            state   <= strb.wrLast ? ST_FLUSH : ST_POST;
          end
        end
        ST_POST: begin
          wrPtr   <= nextPtr;
          postCnt <= postCnt + LW'(1);
          if (strb.wrLast) state <= ST_FLUSH;
        end
        default: begin
          if (commitLast) begin
            doneBit  <= 1'b1;
            startReg <= wrPtr;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/trig_capture_datapath.sv
module trig_capture_datapath
  import trig_capture_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int AW      = 6,
  parameter int WR_LAT  = 2
) (
  input  logic               clk,
  input  logic               rstAct,
  input  logic [PROBE_W-1:0] probeIn,
  input  logic               trigIn,
  input  trig_mode_e         trigMode,
  input  wr_strobe_t         strb,
  input  logic [AW-1:0]      wrAddr,
  output logic               trigHit,
  output logic               commitLast,
  input  logic [AW-1:0]      memRdAddr,
  output logic [PROBE_W-1:0] memRdData
);
  localparam int SLOTS = 1 << AW;
  localparam int LAST  = WR_LAT - 1;

  logic [PROBE_W-1:0] probeQ;
  logic               trigQ;
  logic               trigPrev;

  logic               pipeWe   [WR_LAT];
  logic               pipeLast [WR_LAT];
  logic [AW-1:0]      pipeAddr [WR_LAT];
  logic [PROBE_W-1:0] pipeData [WR_LAT];

  logic [PROBE_W-1:0] mem [SLOTS];

  // Input sampling, every cycle
  always_ff @(posedge clk) begin
    if (rstAct) begin
      trigQ    <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      trigQ    <= trigIn;
      trigPrev <= trigQ;
    end
    probeQ <= probeIn;
  end

  always_comb begin
    case (trigMode)
      TRIG_RISE: trigHit = trigQ & ~trigPrev;
      TRIG_FALL: trigHit = ~trigQ & trigPrev;
      TRIG_HIGH: trigHit = trigQ;
      default:   trigHit = ~trigQ;
    endcase
  end

  // Data and address travel through the same delay stages so they stay paired
  always_ff @(posedge clk) begin
    if (rstAct) begin
      for (int s = 0; s < WR_LAT; s++) begin
        pipeWe[s]   <= 1'b0;
        pipeLast[s] <= 1'b0;
      end
    end else begin
      pipeWe[0]   <= strb.wrEn;
      pipeLast[0] <= strb.wrEn & strb.wrLast;
      for (int s = 1; s < WR_LAT; s++) begin
        pipeWe[s]   <= pipeWe[s-1];
        pipeLast[s] <= pipeLast[s-1];
      end
    end
    pipeAddr[0] <= wrAddr;
    pipeData[0] <= probeQ;
    for (int s = 1; s < WR_LAT; s++) begin
      pipeAddr[s] <= pipeAddr[s-1];
      pipeData[s] <= pipeData[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (pipeWe[LAST]) mem[pipeAddr[LAST]] <= pipeData[LAST];
  end

  assign commitLast = pipeWe[LAST] & pipeLast[LAST];
  assign memRdData  = mem[memRdAddr];
endmodule

// File: rtl/trig_capture_top.sv
module trig_capture_top
  import trig_capture_pkg::*;
#(
  parameter int PROBE_W         = 8,
  parameter int MEM_DEPTH       = 64,
  parameter int BUS_W           = 16,
  parameter int WR_LAT          = 2,
  parameter bit RST_ACTIVE_HIGH = 1'b0,
  localparam int AW             = $clog2(MEM_DEPTH),
  localparam int LW             = AW + 1
) (
  input  logic               clk,
  input  logic               rstIn,
  input  logic [PROBE_W-1:0] probeIn,
  input  logic               trigIn,
  input  logic               busWe,
  input  logic [1:0]         busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  input  logic [AW-1:0]      memRdAddr,
  output logic [PROBE_W-1:0] memRdData,
  output logic               captureDone
);
  logic          rstAct;
  logic          trigHit;
  logic          commitLast;
  logic          armBit;
  trig_mode_e    trigMode;
  wr_strobe_t    strb;
  logic [AW-1:0] wrAddr;
  logic [LW-1:0] recLen;

  if (RST_ACTIVE_HIGH) begin : g_rst_high
    assign rstAct = rstIn;
  end else begin : g_rst_low
    assign rstAct = ~rstIn;
  end

  trig_capture_ctrl #(
    .MEM_DEPTH(MEM_DEPTH), .AW(AW), .LW(LW), .BUS_W(BUS_W)
  ) u_ctrl (
    .clk(clk), .rstAct(rstAct),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .trigHit(trigHit), .commitLast(commitLast), .trigMode(trigMode),
    .strb(strb), .wrAddr(wrAddr), .captureDone(captureDone),
    .armBit(armBit), .recLen(recLen)
  );

  trig_capture_datapath #(
    .PROBE_W(PROBE_W), .AW(AW), .WR_LAT(WR_LAT)
  ) u_dp (
    .clk(clk), .rstAct(rstAct),
    .probeIn(probeIn), .trigIn(trigIn), .trigMode(trigMode),
    .strb(strb), .wrAddr(wrAddr), .trigHit(trigHit), .commitLast(commitLast),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
  import trig_capture_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LW    = 7,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstAct,
  input logic             captureDone,
  input logic             armBit,
  input logic             commitLast,
  input wr_strobe_t       strb,
  input logic [AW-1:0]    wrAddr,
  input logic [LW-1:0]    recLen,
  input logic [BUS_W-1:0] busRdata
);
  assert_rdata_width_R1: assert property (@(posedge clk) disable iff (rstAct)
    busRdata[BUS_W-1:REG_W] == '0);

  assert_addr_in_ring_R4: assert property (@(posedge clk) disable iff (rstAct)
    strb.wrEn |-> (LW'(wrAddr) < recLen));

  assert_last_is_write_R5: assert property (@(posedge clk) disable iff (rstAct)
    strb.wrLast |-> strb.wrEn);

  assert_done_after_commit_R8: assert property (@(posedge clk) disable iff (rstAct)
    $rose(captureDone) |-> $past(commitLast));

  assert_arm_cleared_R9: assert property (@(posedge clk) disable iff (rstAct)
    $rose(captureDone) |-> !armBit);

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rstAct)
    (captureDone && !armBit) |-> !strb.wrEn);
endmodule

bind trig_capture_top trig_capture_chk #(.AW(AW), .LW(LW), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstAct(rstAct), .captureDone(captureDone), .armBit(armBit),
  .commitLast(commitLast), .strb(strb), .wrAddr(wrAddr), .recLen(recLen),
  .busRdata(busRdata)
);

// File: tb/trig_capture_top_tb.sv
module trig_capture_top_tb;
  localparam int PROBE_W   = 8;
  localparam int MEM_DEPTH = 64;
  localparam int BUS_W     = 16;
  localparam int AW        = 6;

  // scenario vector: {type[1:0], split[1:0], depth[6:0]}
  localparam logic [10:0] SCEN [6] = '{
    {2'd0, 2'd0, 7'd10},
    {2'd1, 2'd1, 7'd0},
    {2'd2, 2'd2, 7'd17},
    {2'd3, 2'd3, 7'd1},
    {2'd0, 2'd2, 7'd100},
    {2'd1, 2'd0, 7'd7}
  };

  logic               clk = 1'b0;
  logic               rstIn;
  logic [PROBE_W-1:0] probeIn = '0;
  logic               trigIn;
  logic               busWe;
  logic [1:0]         busAddr;
  logic [BUS_W-1:0]   busWdata;
  logic [BUS_W-1:0]   busRdata;
  logic [AW-1:0]      memRdAddr;
  logic [PROBE_W-1:0] memRdData;
  logic               captureDone;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) probeIn <= probeIn + 8'd1;

  trig_capture_top u_dut (
    .clk(clk), .rstIn(rstIn), .probeIn(probeIn), .trigIn(trigIn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .captureDone(captureDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic memRead(input int a, output int v);
    memRdAddr = AW'(a);
    #1;
    v = int'(memRdData);
  endtask

  function automatic int ringLen(input int depth);
    return (depth == 0 || depth > MEM_DEPTH) ? MEM_DEPTH : depth;
  endfunction

  function automatic int preCount(input int len, input int split);
    int p;
    p = (split == 0) ? 3 : (split == 2) ? 7 : 5;
    return (len * p) / 10;
  endfunction

  task automatic waitDone();
    for (int k = 0; k < 400 && !captureDone; k++) @(negedge clk);
  endtask

  task automatic runScen(input int ty, input int sp, input int depth);
    int len, pre, v, s, rd;
    logic base;
    len  = ringLen(depth);
    pre  = preCount(len, sp);
    base = (ty == 1 || ty == 3);
    trigIn = base;
    busWrite(2'd1, BUS_W'(depth));
    busWrite(2'd0, BUS_W'((sp << 3) | (ty << 1)));
    repeat (3) @(negedge clk);
    busWrite(2'd0, BUS_W'((sp << 3) | (ty << 1) | 1));
    @(negedge clk);
    check("R10 done cleared by arm", int'(captureDone), 0);
    repeat (pre + 4) @(negedge clk);
    #1;
    trigIn = ~base;
    v = int'(probeIn);
    waitDone();
    @(negedge clk);
    trigIn = base;
    check("R8 captureDone", int'(captureDone), 1);
    busRead(2'd2, rd);
    check("R8 status done bit", rd & 1, 1);
    busRead(2'd0, rd);
    check("R9 arm bit cleared", rd & 1, 0);
    busRead(2'd3, s);
    for (int i = 0; i < len; i++) begin
      memRead((s + i) % len, rd);
      check("R5/R6 window sample", rd, (v - pre + i) & 255);
    end
  endtask

  initial begin
    int rd, s, v2, vsave;
    rstIn = 1'b0; trigIn = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0; memRdAddr = '0;
    repeat (4) @(negedge clk);
    rstIn = 1'b1;
    @(negedge clk);

    // R2: defaults
    check("R2 captureDone reset", int'(captureDone), 0);
    busRead(2'd0, rd); check("R2 ctrl default", rd, 8);
    busRead(2'd1, rd); check("R2 depth default", rd, 32);
    busRead(2'd2, rd); check("R2 status default", rd, 0);
    busRead(2'd3, rd); check("R2 start default", rd, 0);

    // R1: 7-bit storage and read-only registers
    busWrite(2'd1, 16'hFF85);
    busRead(2'd1, rd); check("R1 depth keeps low 7 bits", rd, 5);
    busWrite(2'd2, 16'hABCD);
    busRead(2'd2, rd); check("R1 status read-only", rd, 0);
    busWrite(2'd3, 16'h003F);
    busRead(2'd3, rd); check("R1 start read-only", rd, 0);

    // R3: reset level
    busWrite(2'd1, 16'h0011);
    rstIn = 1'b0;
    repeat (2) @(negedge clk);
    rstIn = 1'b1;
    @(negedge clk);
    busRead(2'd1, rd); check("R3 reset restores depth", rd, 32);

    // table of scenarios (R4, R5, R6, R8, R10)
    for (int n = 0; n < 6; n++)
      runScen(int'(SCEN[n][10:9]), int'(SCEN[n][8:7]), int'(SCEN[n][6:0]));

    // R7: early edge ignored; depth 20, split 70/30 -> pre 14
    trigIn = 1'b0;
    busWrite(2'd1, 16'd20);
    busWrite(2'd0, 16'h0011);
    repeat (3) @(negedge clk);
    #1 trigIn = 1'b1;
    repeat (4) @(negedge clk);
    trigIn = 1'b0;
    repeat (20) @(negedge clk);
    #1 trigIn = 1'b1;
    v2 = int'(probeIn);
    waitDone();
    @(negedge clk);
    check("R7 capture finished", int'(captureDone), 1);
    busRead(2'd3, s);
    memRead((s + 14) % 20, rd); check("R7 trigger sample is late edge", rd, v2 & 255);
    memRead(s % 20, rd);        check("R7 oldest sample", rd, (v2 - 14) & 255);
    vsave = rd;

    // R9: second edge after completion has no effect
    trigIn = 1'b0;
    repeat (3) @(negedge clk);
    trigIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R9 done held", int'(captureDone), 1);
    busRead(2'd3, rd); check("R9 start unchanged", rd, s);
    busRead(2'd0, rd); check("R9 arm stays clear", rd & 1, 0);
    memRead((s + 14) % 20, rd); check("R9 trigger sample kept", rd, v2 & 255);
    memRead(s % 20, rd);        check("R9 oldest sample kept", rd, vsave);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule